// File: doc/BRIEF.md
# Digital Quadrature Up-Mixer with Per-Profile Sideband Select

This block combines a baseband I/Q sample pair with a quadrature carrier pair (cosine and sine samples) into one real, signed sample stream. It produces a new output on every system clock, at the same rate that feeds the downstream DAC. Baseband interpolation and carrier synthesis happen elsewhere. Here the block forms the two products, combines them, rounds the result and clips it to the output width.

The sign used to combine the products comes from a small set of sideband-select bits, one bit per profile. A profile index picks which bit applies. With the bit clear, the block subtracts the Q·sin product from the I·cos product. With the bit set, it adds the two products, which places the modulated spectrum on the other side of the carrier. Both products are formed at full precision with identical scaling, so the I and Q paths have no gain or phase mismatch.

Top module: `quad_mixer`

## Requirements
- R1: When the sideband-select bit of the active profile is 0, the output equals I·cos − Q·sin.
- R2: When the sideband-select bit of the active profile is 1, the output equals I·cos + Q·sin.
- R3: `inv_bits[k]` is the sideband-select bit of profile k, and `prof_sel` (an unsigned index) chooses profile k. With four profiles, only the bit at the selected index affects the output.
- R4: The latency from inputs to `mod_out` is exactly two clocks, and a new result appears every clock.
- R5: Inputs are Q1.15 values. Both products are kept at full 32-bit precision before the combine. The combined value is divided by 2^15 and rounded half toward plus infinity: add 2^14, then shift right arithmetically by 15.
- R6: A rounded result above 32767 is output as 32767. It never wraps.
- R7: A rounded result below −32768 is output as −32768. It never wraps.
- R8: The profile index and sideband-select bits are sampled together with the data they apply to. A change affects only samples entering on or after that clock, and samples already in the pipeline are not altered.
- R9: A synchronous active-high `rst` forces `mod_out` to 0 on the next clock. The output stays 0 for the first clock after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| i_smp | input | 16 | Baseband in-phase sample, signed Q1.15 |
| q_smp | input | 16 | Baseband quadrature sample, signed Q1.15 |
| cos_smp | input | 16 | Carrier cosine sample, signed Q1.15 |
| sin_smp | input | 16 | Carrier sine sample, signed Q1.15 |
| prof_sel | input | 2 | Active profile index |
| inv_bits | input | 4 | Sideband-select bit for each profile |
| mod_out | output | 16 | Modulated output sample, signed Q1.15 |

## Verification
Saturation and the sideband sign meet in a single cycle when both products are near full scale. In that case the add-or-subtract decision alone decides whether the sum clips or cancels to zero. The bench drives the same full-scale operands under an inverting and a non-inverting profile, and a further vector in which mixed signs give a small negative result after rounding. Each result is compared against an independent wide-integer model two clocks after its inputs were applied. Profile changes are also made back to back, alongside in-flight samples, to confirm that the sign follows its own sample through the pipeline.

// File: rtl/qmod_pkg.sv
package qmod_pkg;

   typedef enum logic [0:0] {
      RND_TRUNC   = 1'b0,
      RND_HALF_UP = 1'b1
   } qmod_round_e;

endpackage

// File: rtl/qmod_mul_stage.sv
module qmod_mul_stage #(
   parameter int A_W = 16,
   parameter int B_W = 16,
   localparam int P_W = A_W + B_W
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic signed [A_W-1:0] a_in,
   input  logic signed [B_W-1:0] b_in,
   output logic signed [P_W-1:0] prod_q
);

   logic signed [P_W-1:0] a_ext;
   logic signed [P_W-1:0] b_ext;
   logic signed [P_W-1:0] prod_d;

   always_comb begin
      a_ext  = P_W'(a_in);
      b_ext  = P_W'(b_in);
      prod_d = a_ext * b_ext;
   end

   always_ff @(posedge clk) begin
      if (rst) prod_q <= '0;
      else     prod_q <= prod_d;
   end

   // R5: full-precision product of the operands of the previous cycle
   assert_full_prod_R5: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (prod_q == P_W'($past(a_in)) * P_W'($past(b_in))));

endmodule

// File: rtl/qmod_profile_pick.sv
module qmod_profile_pick #(
   parameter int NUM_PROF = 4,
   localparam int SEL_W = (NUM_PROF > 1) ? $clog2(NUM_PROF) : 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [SEL_W-1:0]    sel,
   input  logic [NUM_PROF-1:0] inv_bits,
   output logic                inv_q
);

   generate
      if (NUM_PROF == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) inv_q <= 1'b0;
            else     inv_q <= inv_bits[0];
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst) inv_q <= 1'b0;
            else     inv_q <= inv_bits[sel];
         end

         // R3/R8: the bit chosen with a sample travels beside it
         assert_prof_align_R8: assert property (@(posedge clk) disable iff (rst)
            !rst |=> (inv_q == $past(inv_bits[sel])));
      end
   endgenerate

endmodule

// File: rtl/qmod_combine_sat.sv
module qmod_combine_sat
   import qmod_pkg::*;
#(
   parameter int          PROD_W  = 32,
   parameter int          OUT_W   = 16,
   parameter int          FRAC    = 15,
   parameter qmod_round_e RND     = RND_HALF_UP,
   localparam int         SUM_W   = PROD_W + 2
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic signed [PROD_W-1:0] p_ic,
   input  logic signed [PROD_W-1:0] p_qs,
   input  logic                     add_qs,
   output logic signed [OUT_W-1:0]  y_q
);

   localparam logic signed [SUM_W-1:0] MAXV =
      {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [SUM_W-1:0] MINV =
      {{(SUM_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   logic signed [SUM_W-1:0] ic_ext;
   logic signed [SUM_W-1:0] qs_ext;
   logic signed [SUM_W-1:0] comb_sum;
   logic signed [SUM_W-1:0] biased;
   logic signed [SUM_W-1:0] scaled;
   logic signed [OUT_W-1:0] y_d;

   always_comb begin
      ic_ext   = SUM_W'(p_ic);
      qs_ext   = SUM_W'(p_qs);
      comb_sum = add_qs ? (ic_ext + qs_ext) : (ic_ext - qs_ext);
   end

   generate
      if (RND == RND_HALF_UP) begin : g_round
         localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (FRAC - 1);
         always_comb biased = comb_sum + HALF;
      end else begin : g_trunc
         always_comb biased = comb_sum;
      end
   endgenerate

   always_comb begin
      scaled = biased >>> FRAC;
      if (scaled > MAXV)      y_d = MAXV[OUT_W-1:0];
      else if (scaled < MINV) y_d = MINV[OUT_W-1:0];
      else                    y_d = scaled[OUT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) y_q <= '0;
      else     y_q <= y_d;
   end

   // R6: an over-range result holds at the positive limit
   assert_clip_hi_R6: assert property (@(posedge clk) disable iff (rst)
      (scaled > MAXV) |=> (y_q == MAXV[OUT_W-1:0]));

   // R7: an under-range result holds at the negative limit
   assert_clip_lo_R7: assert property (@(posedge clk) disable iff (rst)
      (scaled < MINV) |=> (y_q == MINV[OUT_W-1:0]));

   // R1/R2: identical operands with opposite products cancel when subtracted
   assert_cancel_R1: assert property (@(posedge clk) disable iff (rst)
      (!add_qs && p_ic == p_qs) |=> (y_q == '0));

endmodule

// File: rtl/quad_mixer.sv
module quad_mixer
   import qmod_pkg::*;
#(
   parameter int          SAMPLE_W = 16,
   parameter int          CARR_W   = 16,
   parameter int          OUT_W    = 16,
   parameter int          NUM_PROF = 4,
   parameter qmod_round_e RND      = RND_HALF_UP,
   localparam int         PROD_W   = SAMPLE_W + CARR_W,
   localparam int         FRAC     = CARR_W - 1,
   localparam int         SEL_W    = (NUM_PROF > 1) ? $clog2(NUM_PROF) : 1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic signed [SAMPLE_W-1:0] i_smp,
   input  logic signed [SAMPLE_W-1:0] q_smp,
   input  logic signed [CARR_W-1:0]   cos_smp,
   input  logic signed [CARR_W-1:0]   sin_smp,
   input  logic [SEL_W-1:0]           prof_sel,
   input  logic [NUM_PROF-1:0]        inv_bits,
   output logic signed [OUT_W-1:0]    mod_out
);

   generate
      if (SAMPLE_W < 2 || CARR_W < 2) begin : g_bad_width
         $error("quad_mixer: sample and carrier widths must be at least 2");
      end
      if (OUT_W < 2 || OUT_W > PROD_W) begin : g_bad_out
         $error("quad_mixer: OUT_W must lie between 2 and the product width");
      end
      if (NUM_PROF < 1 || (NUM_PROF & (NUM_PROF - 1)) != 0) begin : g_bad_prof
         $error("quad_mixer: NUM_PROF must be a power of two");
      end
   endgenerate

   logic signed [PROD_W-1:0] prod_ic;
   logic signed [PROD_W-1:0] prod_qs;
   logic                     add_qs;

   qmod_mul_stage #(.A_W(SAMPLE_W), .B_W(CARR_W)) u_mul_i (
      .clk    (clk),
      .rst    (rst),
      .a_in   (i_smp),
      .b_in   (cos_smp),
      .prod_q (prod_ic)
   );

   qmod_mul_stage #(.A_W(SAMPLE_W), .B_W(CARR_W)) u_mul_q (
      .clk    (clk),
      .rst    (rst),
      .a_in   (q_smp),
      .b_in   (sin_smp),
      .prod_q (prod_qs)
   );

   qmod_profile_pick #(.NUM_PROF(NUM_PROF)) u_prof (
      .clk      (clk),
      .rst      (rst),
      .sel      (prof_sel),
      .inv_bits (inv_bits),
      .inv_q    (add_qs)
   );

   qmod_combine_sat #(
      .PROD_W (PROD_W),
      .OUT_W  (OUT_W),
      .FRAC   (FRAC),
      .RND    (RND)
   ) u_comb (
      .clk    (clk),
      .rst    (rst),
      .p_ic   (prod_ic),
      .p_qs   (prod_qs),
      .add_qs (add_qs),
      .y_q    (mod_out)
   );

   // R9: reset clears the output on the following clock
   assert_reset_zero_R9: assert property (@(posedge clk)
      rst |=> (mod_out == '0));

   // R4: zero operands two clocks back give a zero output
   assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
      (i_smp == '0 && q_smp == '0) |=> ##1 (rst || $past(rst) || mod_out == '0));

endmodule

// File: tb/sim_quad_mixer.sv
`timescale 1ns/1ps
module sim_quad_mixer;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic signed [15:0] i_smp = '0;
   logic signed [15:0] q_smp = '0;
   logic signed [15:0] cos_smp = '0;
   logic signed [15:0] sin_smp = '0;
   logic [1:0]         prof_sel = '0;
   logic [3:0]         inv_bits = 4'b1010;
   logic signed [15:0] mod_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   quad_mixer u0 (
      .clk(clk), .rst(rst), .i_smp(i_smp), .q_smp(q_smp),
      .cos_smp(cos_smp), .sin_smp(sin_smp), .prof_sel(prof_sel),
      .inv_bits(inv_bits), .mod_out(mod_out)
   );

   // columns: I, Q, cos, sin, profile, expected (profiles 1 and 3 invert)
   localparam int NV = 15;
   localparam int TV [NV][6] = '{
      '{ 16384,      0,  16384,      0, 0,   8192},  // R1
      '{     0,  16384,      0,  16384, 0,  -8192},  // R1
      '{     0,  16384,      0,  16384, 1,   8192},  // R2
      '{ 16384,  16384,  16384,  16384, 2,      0},  // R1
      '{ 16384,  16384,  16384,  16384, 3,  16384},  // R2
      '{-32768, -32768, -32768,  32767, 0,  32767},  // R6
      '{-32768,  32767,  32767,  32767, 0, -32768},  // R7
      '{     1,      0,  16384,      0, 0,      1},  // R5 half rounds up
      '{    -1,      0,  16384,      0, 0,      0},  // R5 minus half rounds up
      '{     3,      0,   8192,      0, 0,      1},  // R5
      '{     1,      0,   8192,      0, 0,      0},  // R5
      '{-32768,      0, -32768,      0, 0,  32767},  // R6 single product
      '{ 32767,  32767,  32767,  32767, 1,  32767},  // R6 with add
      '{ 32767, -32768,  32767,  32767, 1,     -1},  // R2 mixed signs
      '{-32768,  32767, -32768, -32768, 1,      1}   // R2
   };

   function automatic int model(int iv, int qv, int cv, int sv, bit inv);
      longint pic = longint'(iv) * longint'(cv);
      longint pqs = longint'(qv) * longint'(sv);
      longint s   = inv ? (pic + pqs) : (pic - pqs);
      longint r   = (s + 64'sd16384) >>> 15;
      if (r > 32767)  return 32767;
      if (r < -32768) return -32768;
      return int'(r);
   endfunction

   task automatic check(string req, int exp);
      total++;
      if (int'(mod_out) != exp) begin
         bad++;
         $display("FAIL %s: mod_out=%0d expected=%0d", req, mod_out, exp);
      end
   endtask

   task automatic drive(int iv, int qv, int cv, int sv, int sel);
      i_smp    = 16'(iv);
      q_smp    = 16'(qv);
      cos_smp  = 16'(cv);
      sin_smp  = 16'(sv);
      prof_sel = 2'(sel);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run hung, actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset state", 0);
      rst = 1'b0;

      // table walked back to back: result checked two clocks after drive (R4)
      for (int k = 0; k < NV + 2; k++) begin
         @(negedge clk);
         if (k >= 2) begin
            check($sformatf("R4 table vector %0d", k - 2), TV[k-2][5]);
            check($sformatf("R5 model vector %0d", k - 2),
                  model(TV[k-2][0], TV[k-2][1], TV[k-2][2], TV[k-2][3],
                        inv_bits[TV[k-2][4]]));
         end
         if (k < NV) drive(TV[k][0], TV[k][1], TV[k][2], TV[k][3], TV[k][4]);
         else        drive(0, 0, 0, 0, 0);
      end

      // R4: exact two-clock latency
      @(negedge clk);
      drive(16384, 0, 16384, 0, 0);
      @(negedge clk);
      check("R4 one clock after drive", 0);
      drive(0, 0, 0, 0, 0);
      @(negedge clk);
      check("R4 two clocks after drive", 8192);
      @(negedge clk);
      check("R4 following zero sample", 0);

      // R3: one-hot bit patterns against every profile index
      for (int b = 0; b < 4; b++) begin
         for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            inv_bits = 4'(1 << b);
            drive(16384, 16384, 16384, 16384, s);
            repeat (2) @(negedge clk);
            check($sformatf("R3 bit %0d profile %0d", b, s), (s == b) ? 16384 : 0);
         end
      end

      // R8: profile alternating every clock stays aligned with data
      @(negedge clk);
      inv_bits = 4'b1010;
      drive(16384, 16384, 16384, 16384, 1);
      @(negedge clk);
      drive(16384, 16384, 16384, 16384, 0);
      @(negedge clk);
      check("R8 alternating profile, first", 16384);
      drive(16384, 16384, 16384, 16384, 3);
      @(negedge clk);
      check("R8 alternating profile, second", 0);
      drive(0, 0, 0, 0, 0);
      @(negedge clk);
      check("R8 alternating profile, third", 16384);

      // R8: bit change after a sample entered leaves it unaltered
      drive(16384, 16384, 16384, 16384, 1);
      @(negedge clk);
      inv_bits = 4'b0000;
      drive(16384, 16384, 16384, 16384, 1);
      @(negedge clk);
      check("R8 late bit change ignored", 16384);
      @(negedge clk);
      check("R8 new bit applies to next sample", 0);

      // R9: mid-stream reset clears and holds through the first released clock
      inv_bits = 4'b1010;
      drive(16384, 0, 16384, 0, 0);
      repeat (2) @(negedge clk);
      check("R1 before reset", 8192);
      rst = 1'b1;
      @(negedge clk);
      check("R9 output cleared by reset", 0);
      rst = 1'b0;
      @(negedge clk);
      check("R9 first clock after release", 0);
      @(negedge clk);
      check("R1 after release", 8192);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule